// File: doc/BRIEF.md
# PS/2 Host-to-Device Byte Sender

This block sends one byte from the host to a PS/2 device over the two shared open-drain lines. It never drives a line high. Each line has a pull-enable output: 1 sinks the line to ground, and 0 lets the external pull-up raise it. The line levels come back in through asynchronous inputs. These are synchronized inside the block, and falling edges on the clock line are found in the system clock domain.

A byte comes in on a valid/ready port. Once a byte is taken, the block runs the request-to-send sequence:
- It pulls the clock line low for a fixed hold time.
- It then lowers the data line as the start bit and lets the clock go.

From then on the device generates the clock. The block changes the data line once per accepted falling edge, in this order:
- the eight data bits;
- an odd parity bit;
- a release of the data line, which forms the stop bit.

On the edge after the stop bit, the block reads the device's acknowledge.

If the acknowledge is missing, if the edges stop arriving, or if the bit position goes out of range, the block sends the same byte again from the start. It does this without outside help. After a successful acknowledge it pulses `tx_done` and raises a blanking window. A companion receiver can use that window to ignore stray edges that follow the turnaround.

Back-pressure rules: `tx_ready` is high only while the block is idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from that point until the acknowledge succeeds. A `tx_valid` presented while `tx_ready` is low is not taken and leaves no trace. `tx_ready` returns high in the same cycle as `tx_done`, so a source that holds `tx_valid` can chain frames with no gap.

Top module: `ps2_host_tx`

## Requirements
- R1: During and after reset the block is idle: `tx_ready` is 1, `ps2_clk_pull` is 0 and `ps2_dat_pull` is 0. While `tx_ready` is 1, both pull outputs are 0.
- R2: A byte is taken on a clock edge with `tx_valid` and `tx_ready` both 1. In the next cycle `tx_ready` is 0. `tx_valid` while `tx_ready` is 0 is ignored: the byte in flight is unchanged, and no extra frame follows.
- R3: After a byte is taken, and after every retry, `ps2_clk_pull` is 1 for exactly INHIBIT_CYC consecutive cycles. During that time `ps2_dat_pull` is 0.
- R4: In the cycle the clock line is let go, `ps2_dat_pull` is 1 (the start bit). A falling edge detected fewer than MIN_GAP_CYC cycles after the release is ignored.
- R5: Each accepted falling edge of the device clock advances one bit. The data line shows the eight data bits least significant first. A bit value b appears as `ps2_dat_pull` = not b. The change happens within SYNC_STAGES+1 cycles of the falling edge at `ps2_clk_i`.
- R6: The accepted edge after the eighth data bit puts out the odd parity bit. This bit is 1 when the byte holds an even number of ones.
- R7: The next accepted edge sets `ps2_dat_pull` to 0, so the line reads 1 as the stop bit.
- R8: At the following accepted edge the block samples `ps2_dat_i`. A 0 there is a successful acknowledge: `tx_done` pulses for one cycle, `tx_ready` goes to 1 in the same cycle, and both lines stay released.
- R9: A 1 sampled at the acknowledge edge is a NACK. There is no `tx_done`, and the same byte is sent again, starting with the clock hold of R3.
- R10: Once the first data bit has been put out, a gap of more than MAX_GAP_CYC cycles with no accepted edge is a timeout. The block then releases data and restarts the same byte with the clock hold. A bit position out of range does the same.
- R11: A falling edge detected fewer than MIN_GAP_CYC cycles after the last accepted edge is a glitch. It neither advances the bit position nor restarts the gap measurement.
- R12: `rx_blank` is 1 for exactly MIN_GAP_CYC consecutive cycles. The window starts in the cycle after each `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tx_valid | input | 1 | Byte offered on `tx_data` |
| tx_ready | output | 1 | Block idle and able to take a byte |
| tx_data | input | DATA_W | Byte to send, least significant bit first on the wire |
| tx_done | output | 1 | One-cycle pulse on successful device acknowledge |
| ps2_clk_i | input | 1 | Level of the shared clock line (asynchronous) |
| ps2_dat_i | input | 1 | Level of the shared data line (asynchronous) |
| ps2_clk_pull | output | 1 | 1 sinks the clock line low, 0 releases it |
| ps2_dat_pull | output | 1 | 1 sinks the data line low, 0 releases it |
| rx_blank | output | 1 | Edge-blanking window for a receiver after a completed send |

## Verification
Two things can land in the same cycle: the successful acknowledge of one frame and the acceptance of the next byte. This is because `tx_ready` rises with `tx_done`. The bench provokes it by holding `tx_valid` with a second byte while the device model finishes the first frame. The result is judged at the lines. Exactly one `tx_done` must occur. A new clock hold of exactly INHIBIT_CYC cycles must follow. The next frame must carry the second byte with its own parity, and the first byte must not be repeated.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [1:0] {
    TXS_IDLE    = 2'd0,
    TXS_INHIBIT = 2'd1,
    TXS_SHIFT   = 2'd2
  } txs_e;

  // Odd parity over a byte: 1 when the byte carries an even count of ones
  function automatic logic odd_parity8(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/ps2tx_line_sync.sv
module ps2tx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic clk_fall,
  output logic dat_s
);

  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic              clk_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sh <= '1;
          dat_sh <= '1;
        end else begin
          clk_sh <= clk_line_i;
          dat_sh <= dat_line_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sh <= '1;
          dat_sh <= '1;
        end else begin
          clk_sh <= {clk_sh[STAGES-2:0], clk_line_i};
          dat_sh <= {dat_sh[STAGES-2:0], dat_line_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= clk_sh[STAGES-1];
  end

  assign clk_fall = clk_prev & ~clk_sh[STAGES-1];
  assign dat_s    = dat_sh[STAGES-1];

endmodule

// File: rtl/ps2tx_gap_timer.sv
module ps2tx_gap_timer #(
  parameter int MIN_GAP = 15000,
  parameter int MAX_GAP = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic too_soon,
  output logic overdue
);

  localparam int          W     = $clog2(MAX_GAP + 2);
  localparam logic [W-1:0] MIN_V = W'(MIN_GAP);
  localparam logic [W-1:0] MAX_V = W'(MAX_GAP);
  localparam logic [W-1:0] SAT_V = W'(MAX_GAP + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  assign too_soon = (cnt < MIN_V);
  assign overdue  = (cnt > MAX_V);

endmodule

// File: rtl/ps2tx_blank_timer.sv
module ps2tx_blank_timer #(
  parameter int LEN = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic blank
);

  localparam int          W     = $clog2(LEN + 1);
  localparam logic [W-1:0] LEN_V = W'(LEN);

  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (start)       left <= LEN_V;
    else if (left != '0)  left <= left - 1'b1;
  end

  assign blank = (left != '0);

endmodule

// File: rtl/ps2tx_frame_ctrl.sv
module ps2tx_frame_ctrl
  import ps2tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INHIBIT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              done,
  input  logic              clk_fall,
  input  logic              dat_s,
  input  logic              too_soon,
  input  logic              overdue,
  output logic              gap_clr,
  output logic              clk_pull,
  output logic              dat_pull
);

  localparam int               SLOT_W   = $clog2(DATA_W + 4);
  localparam logic [SLOT_W-1:0] SL_FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SL_LASTD = SLOT_W'(DATA_W);
  localparam logic [SLOT_W-1:0] SL_PAR   = SLOT_W'(DATA_W + 1);
  localparam logic [SLOT_W-1:0] SL_STOP  = SLOT_W'(DATA_W + 2);
  localparam logic [SLOT_W-1:0] SL_ACK   = SLOT_W'(DATA_W + 3);
  localparam int               HOLD_W   = $clog2(INHIBIT_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(INHIBIT_CYC - 1);

  txs_e              state;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] shreg;
  logic [HOLD_W-1:0] hold_cnt;
  logic              dat_pull_q;
  logic              done_q;

  logic edge_ok;
  logic hold_last;
  logic gap_fault;
  logic par_bit;

  assign edge_ok   = (state == TXS_SHIFT) && clk_fall && !too_soon;
  assign hold_last = (state == TXS_INHIBIT) && (hold_cnt == HOLD_END);
  assign gap_fault = (state == TXS_SHIFT) && !edge_ok && overdue && (slot > SL_FIRST);
  assign gap_clr   = hold_last || edge_ok;

  generate
    if (DATA_W == 8) begin : g_par8
      assign par_bit = odd_parity8(byte_q);
    end else begin : g_parn
      assign par_bit = ~(^byte_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TXS_IDLE;
      slot       <= SL_FIRST;
      byte_q     <= '0;
      shreg      <= '0;
      hold_cnt   <= '0;
      dat_pull_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        TXS_IDLE: begin
          if (req_valid) begin
            byte_q   <= req_data;
            shreg    <= req_data;
            slot     <= SL_FIRST;
            hold_cnt <= '0;
            state    <= TXS_INHIBIT;
          end
        end
        TXS_INHIBIT: begin
          if (hold_last) begin
            dat_pull_q <= 1'b1;
            state      <= TXS_SHIFT;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        TXS_SHIFT: begin
          if (edge_ok) begin
            if (slot >= SL_FIRST && slot <= SL_LASTD) begin
              dat_pull_q <= ~shreg[0];
              shreg      <= shreg >> 1;
              slot       <= slot + 1'b1;
            end else if (slot == SL_PAR) begin
              dat_pull_q <= ~par_bit;
              slot       <= slot + 1'b1;
            end else if (slot == SL_STOP) begin
              dat_pull_q <= 1'b0;
              slot       <= slot + 1'b1;
            end else if (slot == SL_ACK && !dat_s) begin
              done_q     <= 1'b1;
              dat_pull_q <= 1'b0;
              slot       <= SL_FIRST;
              state      <= TXS_IDLE;
            end else begin
              dat_pull_q <= 1'b0;
              slot       <= SL_FIRST;
              shreg      <= byte_q;
              hold_cnt   <= '0;
              state      <= TXS_INHIBIT;
            end
          end else if (gap_fault) begin
            dat_pull_q <= 1'b0;
            slot       <= SL_FIRST;
            shreg      <= byte_q;
            hold_cnt   <= '0;
            state      <= TXS_INHIBIT;
          end
        end
        default: begin
          state      <= TXS_IDLE;
          dat_pull_q <= 1'b0;
        end
      endcase
    end
  end

  assign req_ready = (state == TXS_IDLE);
  assign done      = done_q;
  assign clk_pull  = (state == TXS_INHIBIT);
  assign dat_pull  = dat_pull_q;

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx #(
  parameter int DATA_W      = 8,
  parameter int INHIBIT_CYC = 50000,
  parameter int MIN_GAP_CYC = 15000,
  parameter int MAX_GAP_CYC = 30000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_done,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_pull,
  output logic              ps2_dat_pull,
  output logic              rx_blank
);

  logic clk_fall;
  logic dat_s;
  logic too_soon;
  logic overdue;
  logic gap_clr;
  logic ready_w;
  logic done_w;

  ps2tx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_line_i (ps2_clk_i),
    .dat_line_i (ps2_dat_i),
    .clk_fall   (clk_fall),
    .dat_s      (dat_s)
  );

  ps2tx_gap_timer #(.MIN_GAP(MIN_GAP_CYC), .MAX_GAP(MAX_GAP_CYC)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (gap_clr),
    .too_soon (too_soon),
    .overdue  (overdue)
  );

  ps2tx_frame_ctrl #(.DATA_W(DATA_W), .INHIBIT_CYC(INHIBIT_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (tx_valid),
    .req_data  (tx_data),
    .req_ready (ready_w),
    .done      (done_w),
    .clk_fall  (clk_fall),
    .dat_s     (dat_s),
    .too_soon  (too_soon),
    .overdue   (overdue),
    .gap_clr   (gap_clr),
    .clk_pull  (ps2_clk_pull),
    .dat_pull  (ps2_dat_pull)
  );

  ps2tx_blank_timer #(.LEN(MIN_GAP_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .start (done_w),
    .blank (rx_blank)
  );

  assign tx_ready = ready_w;
  assign tx_done  = done_w;

endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk #(
  parameter int INHIBIT_CYC = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_done,
  input logic ps2_clk_pull,
  input logic ps2_dat_pull,
  input logic rx_blank
);

  localparam int          RW    = $clog2(INHIBIT_CYC + 2);
  localparam logic [RW-1:0] INH_V = RW'(INHIBIT_CYC);

  logic [RW-1:0] pull_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pull_run <= '0;
    else if (!ps2_clk_pull) pull_run <= '0;
    else if (pull_run != '1) pull_run <= pull_run + 1'b1;
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!ps2_clk_pull && !ps2_dat_pull));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && ps2_clk_pull));

  assert_hold_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull) |-> (pull_run == INH_V));

  assert_hold_data_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_pull |-> !ps2_dat_pull);

  assert_start_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull) |-> ps2_dat_pull);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_ready);

  assert_blank_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> rx_blank);

endmodule

bind ps2_host_tx ps2_host_tx_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_done      (tx_done),
  .ps2_clk_pull (ps2_clk_pull),
  .ps2_dat_pull (ps2_dat_pull),
  .rx_blank     (rx_blank)
);

// File: tb/ps2_host_tx_tb_top.sv
`timescale 1ns/1ps
module ps2_host_tx_tb_top;

  localparam int INH  = 40;
  localparam int MINC = 12;
  localparam int MAXC = 60;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       tx_valid = 1'b0;
  logic [7:0] tx_data  = '0;
  logic       tx_ready, tx_done, clk_pull, dat_pull, rx_blank;
  logic       dev_clk = 1'b1;
  logic       dev_dat = 1'b0;
  logic       line_clk, line_dat;

  assign line_clk = dev_clk & ~clk_pull;
  assign line_dat = ~dev_dat & ~dat_pull;

  ps2_host_tx #(
    .DATA_W(8), .INHIBIT_CYC(INH), .MIN_GAP_CYC(MINC),
    .MAX_GAP_CYC(MAXC), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_done(tx_done), .ps2_clk_i(line_clk),
    .ps2_dat_i(line_dat), .ps2_clk_pull(clk_pull), .ps2_dat_pull(dat_pull),
    .rx_blank(rx_blank)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int hold_run = 0;
  int blank_run = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return (ones % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  // Monitors: clock hold length (R3), blank window length (R12), done count
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_done) done_cnt++;
      if (clk_pull) hold_run++;
      else if (hold_run > 0) begin
        check(hold_run == INH, "R3 clock hold length", hold_run, INH);
        hold_run = 0;
      end
      if (rx_blank) blank_run++;
      else if (blank_run > 0) begin
        check(blank_run == MINC, "R12 blank window length", blank_run, MINC);
        blank_run = 0;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    bit taken = 0;
    tx_data  = b;
    tx_valid = 1'b1;
    while (!taken) begin
      if (tx_ready) taken = 1;
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  // mode 0 normal, 1 NACK, 2 gap timeout, 3 glitches (early and mid-frame)
  task automatic dev_frame(input int mode, input logic [7:0] b);
    logic [9:0] seen;
    int d0;
    seen = '0;
    while (!clk_pull) @(negedge clk);
    while (clk_pull) @(negedge clk);
    check(dat_pull == 1'b1, "R4 start bit at clock release", dat_pull, 1);
    if (mode == 3) begin
      repeat (2) @(negedge clk);
      dev_clk = 1'b0;
      repeat (3) @(negedge clk);
      dev_clk = 1'b1;
    end
    repeat (20) @(negedge clk);
    d0 = done_cnt;
    for (int k = 1; k <= 11; k++) begin
      dev_clk = 1'b0;
      if (mode == 3 && k == 4) begin
        repeat (3) @(negedge clk);
        dev_clk = 1'b1;
        repeat (3) @(negedge clk);
        dev_clk = 1'b0;
        repeat (HALF - 6) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (k <= 10) seen[k-1] = line_dat;
      if (mode == 2 && k == 3) begin
        dev_clk = 1'b1;
        repeat (MAXC + 15) @(negedge clk);
        check(clk_pull == 1'b1, "R10 retry hold after gap", clk_pull, 1);
        check(dat_pull == 1'b0, "R10 data released on timeout", dat_pull, 0);
        return;
      end
      if (k == 11) dev_dat = 1'b0;
      dev_clk = 1'b1;
      if (k == 10 && mode != 1) dev_dat = 1'b1;
      if (k < 11) repeat (HALF) @(negedge clk);
    end
    check(seen[7:0] == b, "R5 data bits lsb first", seen[7:0], b);
    check(seen[8] == par_of(b), "R6 odd parity bit", seen[8], par_of(b));
    check(seen[9] == 1'b1, "R7 stop bit released", seen[9], 1);
    if (mode == 1) begin
      check(clk_pull == 1'b1, "R9 NACK starts retry hold", clk_pull, 1);
      check(done_cnt == d0, "R9 no done on NACK", done_cnt, d0);
    end else begin
      check(done_cnt == d0 + 1, "R8 one done on ack", done_cnt, d0 + 1);
    end
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    check(clk_pull == 1'b0 && dat_pull == 1'b0, "R1 lines released in reset",
          {clk_pull, dat_pull}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b1, "R1 idle after reset", tx_ready, 1);

    // Directed bytes: parity both ways, all-zero, all-one
    send(8'hA5); dev_frame(0, 8'hA5);
    send(8'h00); dev_frame(0, 8'h00);
    send(8'hFF); dev_frame(0, 8'hFF);
    send(8'h01); dev_frame(0, 8'h01);
    repeat (MINC + 5) @(negedge clk);

    // R2: request while busy is ignored
    send(8'h3C);
    fork
      dev_frame(0, 8'h3C);
      begin
        repeat (30) @(negedge clk);
        tx_data  = 8'hC3;
        tx_valid = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b0, "R2 busy during frame", tx_ready, 0);
        tx_valid = 1'b0;
      end
    join
    repeat (80) @(negedge clk);
    check(clk_pull == 1'b0 && tx_ready == 1'b1, "R2 ignored request made no frame",
          {clk_pull, tx_ready}, 1);

    // R9: NACK then retry of same byte
    send(8'h5A); dev_frame(1, 8'h5A); dev_frame(0, 8'h5A);

    // R10: gap timeout then retry of same byte
    send(8'h96); dev_frame(2, 8'h96); dev_frame(0, 8'h96);

    // R4 early edge and R11 mid-frame glitch are ignored
    send(8'h7E); dev_frame(3, 8'h7E);

    // Done and next acceptance in the same cycle
    send(8'h11);
    fork
      send(8'h22);
      dev_frame(0, 8'h11);
    join
    dev_frame(0, 8'h22);
    repeat (MINC + 5) @(negedge clk);

    // Random bytes, some with glitches
    for (int i = 0; i < 10; i++) begin
      logic [7:0] rb;
      int md;
      rb = 8'($urandom);
      md = ($urandom % 2 == 0) ? 0 : 3;
      send(rb);
      dev_frame(md, rb);
    end
    repeat (MINC + 5) @(negedge clk);
    check(tx_ready == 1'b1 && clk_pull == 1'b0, "R1 idle at end", tx_ready, 1);

    summary();
    $finish;
  end

endmodule